// File: doc/BRIEF.md
# Banked Address Window Decoder

This block sits between a 16-bit CPU address bus and a wider 24-bit physical space. A software-programmed window `[win_lo, win_hi)` relocates every address inside it to a 24-bit location. That location is built from the offset into the window, plus the page number shifted left by a programmable amount, plus a programmable base. Addresses outside the window leave the block unchanged, zero-extended.

In parallel, the block decodes which on-chip region the CPU address belongs to.
- The I/O register block and internal RAM each take a 4 KiB-aligned base from one nibble of a writable init byte.
- The EEPROM and NVRAM regions sit at fixed, parameterised locations.
- Overlaps are resolved by a fixed priority, and an address that no region claims raises an unmapped flag.

All configuration is held in registers loaded through a single write port. The outputs are registered, so a result appears one clock after its address.

Top module: `addr_window_map`

## Requirements
- R1: After synchronous reset, the window is empty (low bound equals high bound, both 0), the page, shift and virtual base are 0, and the init byte is 0x01. The outputs read extended address 0, region select 0 and unmapped 1 until the first address is presented.
- R2: A CPU address A with win_lo <= A < win_hi yields extended address ((A - win_lo) + (page << shift) + vbase) modulo 2^24.
- R3: A CPU address outside the half-open window yields the address zero-extended to 24 bits; the address equal to win_hi is outside.
- R4: The configuration write port decodes `cfg_sel` as follows:
  - 0 = page (low 8 bits)
  - 1 = window low bound (low 16 bits)
  - 2 = window high bound (low 16 bits)
  - 3 = shift (low 4 bits)
  - 4 = virtual base (24 bits)
  - 5 = init byte (low 8 bits)
  - 6 and 7 are ignored.

  A write takes effect for addresses presented in the following cycle.
- R5: The I/O region is claimed when address bits 15:12 equal init bits 3:0 and bits 11:0 are below the I/O size (64 bytes by default, 1024 when LARGE_IO=1).
- R6: The RAM region is claimed when address bits 15:12 equal init bits 7:4 and bits 11:0 are below RAM_BYTES (256 by default).
- R7: The EEPROM region is 0xB600–0xB7FF and the NVRAM region is 0xB400–0xB7FF by default.
- R8: `region_sel` is one-hot, with bit 0 = I/O, bit 1 = EEPROM, bit 2 = NVRAM and bit 3 = RAM. When several regions claim an address, the priority is I/O, then EEPROM, then NVRAM, then RAM.
- R9: `unmapped` is 1 exactly when no region claims the address, and `region_sel` is then 0.
- R10: Outputs are registered: each output reflects the address and configuration present at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration field select |
| cfg_wdata | input | 24 | Configuration write data |
| cpu_addr | input | 16 | CPU address |
| ext_addr | output | 24 | Translated extended address |
| region_sel | output | 4 | One-hot region select (I/O, EEPROM, NVRAM, RAM) |
| unmapped | output | 1 | No region claims the address |

## Verification
The address space is swept at a stride of 7 under four configurations:
- reset defaults;
- a large window with a high shift, with I/O and RAM stacked on the EEPROM/NVRAM page;
- a small window where page shift and base overflow 24 bits;
- an inverted, hence empty, window with I/O and RAM both at page 0.

Each sweep is topped up with the exact edges: window bounds ±1, the I/O and RAM limits, and the EEPROM/NVRAM boundaries. These edges separate off-by-one window and size compares from correct ones. The overlapping configurations separate a correct priority order from a swapped one. The overflowing configuration exposes missing truncation. A write to an unused select, followed by a full sweep, shows it changed nothing.

// File: rtl/addr_map_pkg.sv
package addr_map_pkg;
  localparam int NUM_REGIONS = 4;
  localparam int RGN_IO  = 0;
  localparam int RGN_EE  = 1;
  localparam int RGN_NV  = 2;
  localparam int RGN_RAM = 3;

  typedef logic [NUM_REGIONS-1:0] region_vec_t;

  typedef enum logic [2:0] {
    CF_PAGE  = 3'd0,
    CF_WLO   = 3'd1,
    CF_WHI   = 3'd2,
    CF_SHIFT = 3'd3,
    CF_VBASE = 3'd4,
    CF_INIT  = 3'd5
  } cfg_field_e;
endpackage

// File: rtl/map_cfg_regs.sv
module map_cfg_regs #(
  parameter int ADDR_W  = 16,
  parameter int EXT_W   = 24,
  parameter int PAGE_W  = 8,
  parameter int SHIFT_W = 4,
  parameter logic [7:0] INIT_RST = 8'h01
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [2:0]         sel,
  input  logic [EXT_W-1:0]   wdata,
  output logic [PAGE_W-1:0]  page_q,
  output logic [ADDR_W-1:0]  win_lo_q,
  output logic [ADDR_W-1:0]  win_hi_q,
  output logic [SHIFT_W-1:0] shift_q,
  output logic [EXT_W-1:0]   vbase_q,
  output logic [7:0]         init_q
);
  import addr_map_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q   <= '0;
      win_lo_q <= '0;
      win_hi_q <= '0;
      shift_q  <= '0;
      vbase_q  <= '0;
      init_q   <= INIT_RST;
    end else if (we) begin
      case (sel)
        CF_PAGE:  page_q   <= wdata[PAGE_W-1:0];
        CF_WLO:   win_lo_q <= wdata[ADDR_W-1:0];
        CF_WHI:   win_hi_q <= wdata[ADDR_W-1:0];
        CF_SHIFT: shift_q  <= wdata[SHIFT_W-1:0];
        CF_VBASE: vbase_q  <= wdata;
        CF_INIT:  init_q   <= wdata[7:0];
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/window_xlate.sv
module window_xlate #(
  parameter int ADDR_W  = 16,
  parameter int EXT_W   = 24,
  parameter int PAGE_W  = 8,
  parameter int SHIFT_W = 4
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [ADDR_W-1:0]  win_lo,
  input  logic [ADDR_W-1:0]  win_hi,
  input  logic [PAGE_W-1:0]  page,
  input  logic [SHIFT_W-1:0] shift,
  input  logic [EXT_W-1:0]   vbase,
  output logic [EXT_W-1:0]   xaddr
);
  logic              in_win;
  logic [ADDR_W-1:0] offset;
  logic [EXT_W-1:0]  reloc;

  always_comb begin
    in_win = (addr >= win_lo) && (addr < win_hi);
    offset = addr - win_lo;
    reloc  = EXT_W'(page) << shift;
    if (in_win) xaddr = EXT_W'(offset) + reloc + vbase;
    else        xaddr = EXT_W'(addr);
  end
endmodule

// File: rtl/region_decode.sv
module region_decode #(
  parameter int ADDR_W    = 16,
  parameter int LARGE_IO  = 0,
  parameter int RAM_BYTES = 256,
  parameter int EE_BASE   = 'hB600,
  parameter int EE_BYTES  = 512,
  parameter int NV_BASE   = 'hB400,
  parameter int NV_BYTES  = 1024
) (
  input  logic [ADDR_W-1:0]          addr,
  input  logic [7:0]                 init,
  output addr_map_pkg::region_vec_t  sel,
  output logic                       none
);
  import addr_map_pkg::*;

  localparam int LOW_W = ADDR_W - 4;
  localparam logic [ADDR_W:0] EE_LO = (ADDR_W+1)'(EE_BASE);
  localparam logic [ADDR_W:0] EE_HI = (ADDR_W+1)'(EE_BASE + EE_BYTES);
  localparam logic [ADDR_W:0] NV_LO = (ADDR_W+1)'(NV_BASE);
  localparam logic [ADDR_W:0] NV_HI = (ADDR_W+1)'(NV_BASE + NV_BYTES);
  localparam logic [LOW_W:0]  RAM_LIM = (LOW_W+1)'(RAM_BYTES);

  logic [3:0]       top_nib;
  logic [LOW_W:0]   low_off;
  logic [ADDR_W:0]  wide;
  logic             io_hit, ee_hit, nv_hit, ram_hit;

  assign top_nib = addr[ADDR_W-1 -: 4];
  assign low_off = {1'b0, addr[LOW_W-1:0]};
  assign wide    = {1'b0, addr};

  generate
    if (LARGE_IO != 0) begin : g_io_large
      localparam logic [LOW_W:0] IO_LIM = (LOW_W+1)'(1024);
      assign io_hit = (top_nib == init[3:0]) && (low_off < IO_LIM);
    end else begin : g_io_small
      localparam logic [LOW_W:0] IO_LIM = (LOW_W+1)'(64);
      assign io_hit = (top_nib == init[3:0]) && (low_off < IO_LIM);
    end
  endgenerate

  assign ee_hit  = (wide >= EE_LO) && (wide < EE_HI);
  assign nv_hit  = (wide >= NV_LO) && (wide < NV_HI);
  assign ram_hit = (top_nib == init[7:4]) && (low_off < RAM_LIM);

  always_comb begin
    sel = '0;
    if (io_hit)       sel[RGN_IO]  = 1'b1;
    else if (ee_hit)  sel[RGN_EE]  = 1'b1;
    else if (nv_hit)  sel[RGN_NV]  = 1'b1;
    else if (ram_hit) sel[RGN_RAM] = 1'b1;
    none = !(io_hit || ee_hit || nv_hit || ram_hit);
  end
endmodule

// File: rtl/addr_window_map.sv
module addr_window_map #(
  parameter int ADDR_W    = 16,
  parameter int EXT_W     = 24,
  parameter int PAGE_W    = 8,
  parameter int SHIFT_W   = 4,
  parameter int LARGE_IO  = 0,
  parameter int RAM_BYTES = 256,
  parameter int EE_BASE   = 'hB600,
  parameter int EE_BYTES  = 512,
  parameter int NV_BASE   = 'hB400,
  parameter int NV_BYTES  = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [EXT_W-1:0]  cfg_wdata,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic [EXT_W-1:0]  ext_addr,
  output logic [3:0]        region_sel,
  output logic              unmapped
);
  import addr_map_pkg::*;

  logic [PAGE_W-1:0]  page_q;
  logic [ADDR_W-1:0]  win_lo_q, win_hi_q;
  logic [SHIFT_W-1:0] shift_q;
  logic [EXT_W-1:0]   vbase_q;
  logic [7:0]         init_q;
  logic [EXT_W-1:0]   xaddr_c;
  region_vec_t        sel_c;
  logic               none_c;

  map_cfg_regs #(
    .ADDR_W(ADDR_W), .EXT_W(EXT_W), .PAGE_W(PAGE_W), .SHIFT_W(SHIFT_W),
    .INIT_RST(8'h01)
  ) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .page_q(page_q), .win_lo_q(win_lo_q), .win_hi_q(win_hi_q),
    .shift_q(shift_q), .vbase_q(vbase_q), .init_q(init_q)
  );

  window_xlate #(
    .ADDR_W(ADDR_W), .EXT_W(EXT_W), .PAGE_W(PAGE_W), .SHIFT_W(SHIFT_W)
  ) u_xlate (
    .addr(cpu_addr), .win_lo(win_lo_q), .win_hi(win_hi_q),
    .page(page_q), .shift(shift_q), .vbase(vbase_q), .xaddr(xaddr_c)
  );

  region_decode #(
    .ADDR_W(ADDR_W), .LARGE_IO(LARGE_IO), .RAM_BYTES(RAM_BYTES),
    .EE_BASE(EE_BASE), .EE_BYTES(EE_BYTES),
    .NV_BASE(NV_BASE), .NV_BYTES(NV_BYTES)
  ) u_region (
    .addr(cpu_addr), .init(init_q), .sel(sel_c), .none(none_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_addr   <= '0;
      region_sel <= '0;
      unmapped   <= 1'b1;
    end else begin
      ext_addr   <= xaddr_c;
      region_sel <= sel_c;
      unmapped   <= none_c;
    end
  end
endmodule

// File: rtl/addr_window_map_chk.sv
module addr_window_map_chk #(
  parameter int ADDR_W   = 16,
  parameter int EXT_W    = 24,
  parameter int PAGE_W   = 8,
  parameter int LARGE_IO = 0
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [EXT_W-1:0]  ext_addr,
  input logic [3:0]        region_sel,
  input logic              unmapped,
  input logic [ADDR_W-1:0] win_lo_q,
  input logic [ADDR_W-1:0] win_hi_q,
  input logic [PAGE_W-1:0] page_q,
  input logic [7:0]        init_q
);
  localparam int IO_SZ = (LARGE_IO != 0) ? 1024 : 64;

  logic outside_win, io_claim;
  assign outside_win = (cpu_addr < win_lo_q) || (cpu_addr >= win_hi_q);
  assign io_claim    = (cpu_addr[ADDR_W-1 -: 4] == init_q[3:0]) &&
                       (int'(cpu_addr[ADDR_W-5:0]) < IO_SZ);

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(region_sel)); // R8
  AST_UNMAPPED_FLAG: assert property (@(posedge clk) disable iff (rst)
    unmapped == (region_sel == 4'b0000)); // R9
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(outside_win)) |-> ext_addr == EXT_W'($past(cpu_addr))); // R3
  AST_IO_FIRST: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(io_claim)) |-> region_sel == 4'b0001); // R8
  AST_RESET_CFG: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (init_q == 8'h01 && win_lo_q == win_hi_q && page_q == '0)); // R1
endmodule

bind addr_window_map addr_window_map_chk #(
  .ADDR_W(ADDR_W), .EXT_W(EXT_W), .PAGE_W(PAGE_W), .LARGE_IO(LARGE_IO)
) u_chk (
  .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .ext_addr(ext_addr),
  .region_sel(region_sel), .unmapped(unmapped), .win_lo_q(win_lo_q),
  .win_hi_q(win_hi_q), .page_q(page_q), .init_q(init_q)
);

// File: tb/addr_window_map_tb.sv
module addr_window_map_tb;
  localparam int CLK_PERIOD = 10;
  localparam int STRIDE = 7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [23:0] cfg_wdata = '0;
  logic [15:0] cpu_addr = '0;
  logic [23:0] ext_addr;
  logic [3:0]  region_sel;
  logic        unmapped;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  int m_page, m_lo, m_hi, m_shift, m_vbase, m_init;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_window_map u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cpu_addr(cpu_addr), .ext_addr(ext_addr),
    .region_sel(region_sel), .unmapped(unmapped)
  );

  function automatic int exp_ext(int a);
    if (a >= m_lo && a < m_hi)
      return ((a - m_lo) + (m_page << m_shift) + m_vbase) & 32'hFF_FFFF;
    return a;
  endfunction

  function automatic int exp_sel(int a);
    bit io, ee, nv, ram;
    io  = ((a >> 12) == (m_init & 15)) && ((a & 4095) < 64);
    ee  = (a >= 'hB600) && (a < 'hB800);
    nv  = (a >= 'hB400) && (a < 'hB800);
    ram = ((a >> 12) == (m_init >> 4)) && ((a & 4095) < 256);
    if (io)  return 1;
    if (ee)  return 2;
    if (nv)  return 4;
    if (ram) return 8;
    return 0;
  endfunction

  function automatic string sel_tag(int s);
    case (s)
      1: return "R5/R8";
      2: return "R7/R8";
      4: return "R7/R8";
      8: return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic note_fail(string tag, int act, int exp);
    n_bad++;
    $display("FAIL %s act=%h exp=%h", tag, act, exp);
  endtask

  // Drive at negedge, check just after the next rising edge (R10: one register)
  task automatic apply(int a);
    int e, s;
    @(negedge clk);
    cpu_addr = 16'(a);
    @(posedge clk);
    #1;
    e = exp_ext(a);
    s = exp_sel(a);
    n_vec++;
    if (int'(ext_addr) != e)
      note_fail((a >= m_lo && a < m_hi) ? "R2" : "R3", int'(ext_addr), e);
    if (int'(region_sel) != s || unmapped != (s == 0))
      note_fail(sel_tag(s), {int'(unmapped), int'(region_sel)}, {int'(s == 0), s});
  endtask

  task automatic write_cfg(int sel, int data);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_sel = 3'(sel);
    cfg_wdata = 24'(data);
    @(posedge clk);
    #1;
    cfg_we = 1'b0;
    case (sel)
      0: m_page  = data & 255;
      1: m_lo    = data & 16'hFFFF;
      2: m_hi    = data & 16'hFFFF;
      3: m_shift = data & 15;
      4: m_vbase = data & 24'hFF_FFFF;
      5: m_init  = data & 255;
      default: ; // R4: selects 6 and 7 leave state unchanged
    endcase
  endtask

  task automatic sweep_and_edges();
    int io_b, ram_b;
    for (int a = 0; a < 65536; a += STRIDE) apply(a);
    io_b  = (m_init & 15) << 12;
    ram_b = (m_init >> 4) << 12;
    // window boundaries (R2/R3)
    apply((m_lo - 1) & 16'hFFFF); apply(m_lo);
    apply((m_hi - 1) & 16'hFFFF); apply(m_hi);
    // fixed regions (R7)
    apply('hB3FF); apply('hB400); apply('hB5FF);
    apply('hB600); apply('hB7FF); apply('hB800);
    // I/O and RAM limits (R5, R6)
    apply(io_b); apply(io_b + 63); apply(io_b + 64);
    apply(ram_b); apply(ram_b + 255); apply(ram_b + 256);
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    m_page = 0; m_lo = 0; m_hi = 0; m_shift = 0; m_vbase = 0; m_init = 1;
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs held at reset values during reset
    n_vec++;
    if (ext_addr !== 24'h0 || region_sel !== 4'h0 || unmapped !== 1'b1)
      note_fail("R1", {int'(unmapped), int'(region_sel)}, 1 << 4);
    @(negedge clk);
    rst = 1'b0;

    // R1: default configuration sweep
    sweep_and_edges();

    // R10: output must not change before the clock edge
    apply('h1234);
    @(negedge clk);
    cpu_addr = 16'h5678;
    #1;
    n_vec++;
    if (ext_addr !== 24'h001234) note_fail("R10", int'(ext_addr), 'h1234);

    // Config A: large window, I/O and RAM stacked on the EEPROM/NVRAM page (R4, R8)
    write_cfg(1, 'h8000); write_cfg(2, 'hC000); write_cfg(0, 'h05);
    write_cfg(3, 14);     write_cfg(4, 'h100000); write_cfg(5, 'hBB);
    sweep_and_edges();

    // Config B: small window, overflow past 24 bits; I/O on EEPROM page
    write_cfg(1, 'h4000); write_cfg(2, 'h4100); write_cfg(0, 'hFF);
    write_cfg(3, 'h1F);   write_cfg(4, 'hFF0000); write_cfg(5, 'h7B);
    write_cfg(5, 'h6B); // I/O at 0xB000, RAM at 0x6000
    // R4: writes to unused selects must leave the mapping intact
    write_cfg(6, 'h123456); write_cfg(7, 'hFFFFFF);
    sweep_and_edges();

    // Config C: inverted (empty) window, I/O and RAM both at page 0
    write_cfg(1, 'hF000); write_cfg(2, 'h1000); write_cfg(5, 'h00);
    sweep_and_edges();

    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end
endmodule